// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Sequencer

This block is a clock-synchronous model of the write-control path of a byte-wide parallel EEPROM. The active-low chip-enable, write-enable and output-enable strobes, the address and the data are sampled on every rising clock edge. Each accepted write strobe places one byte into a page buffer. The low address bits select the byte position and the high bits select the row. A load timer that restarts with every accepted byte decides when a burst of loads has finished. A self-timed programming phase then copies the buffered bytes into the storage array. During that phase, reads return polling status instead of array data.

The load window, the programming time, the minimum strobe width and the power-up inhibit window are all parameters counted in clock cycles, so simulation can use short values. With the default settings the array has 16 rows of 64 bytes, which keeps elaboration small. Raising `ROW_W` to 9 gives the full 32K-byte organisation.

Top module: `eeprom_page_writer`

## Requirements
- R1: The block sees a write strobe only while `ce_n`=0, `we_n`=0 and `oe_n`=1, and a read only while `ce_n`=0, `oe_n`=0 and `we_n`=1. `dout_en` equals the read condition sampled at the previous edge. `dout` is 0 whenever `dout_en` is 0.
- R2: The address of a byte is the value sampled in the first cycle the write strobe is active. This is the later of the two enable falls. The data is the value sampled in the last active cycle, before the earlier of the two rises.
- R3: A write strobe active for fewer than `MIN_PULSE` sampled cycles loads no byte and starts no programming.
- R4: A byte is accepted in the cycle its strobe ends. Programming begins after `LOAD_CYC` strobe-inactive cycles with no further accepted byte. The timer resets on each accepted byte and pauses while a strobe is active.
- R5: Programming lasts `PROG_CYC` cycles. Afterwards every loaded byte position holds its new value, and positions not loaded keep their previous contents.
- R6: Bits [5:0] of the address select the byte within the page. The row that gets programmed is the row of the most recently accepted byte.
- R7: During programming, a read returns bit 7 equal to the inverse of bit 7 of the last loaded byte, bit 6 equal to a toggle flag, and bits 5..0 equal to 0. The toggle is cleared when programming starts and flips at the first cycle of each read, so the first read shows 1. Array data returns after programming ends.
- R8: A write strobe that ends during programming is ignored. The page buffer is emptied when programming completes, so a later page programs only its own bytes.
- R9: For `INIT_CYC` cycles after reset, write strobes are ignored.
- R10: Reset sets every array byte to 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ROW_W+6 | Byte address: row above, column in bits [5:0] |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data or polling status |
| dout_en | output | 1 | Output drive enable for `dout` |

## Verification
The checker watches, on every cycle, the parts of the behaviour that can be seen edge by edge:
- `dout_en` follows the read condition, and `dout` is quiet when it is not driven.
- The page buffer stays empty and the array is never written during the inhibit window.
- Array writes happen only while programming runs.
- The buffer is frozen during programming and empty after it.
- The polling byte carries the inverted last bit 7 and zero low bits.

The bench scenarios cover what needs history:
- the data captured at the early rise versus the address captured at the late fall;
- rejection of short strobes;
- the pausing load timer;
- row selection from the last byte;
- the toggle sequence;
- which bytes of which rows end up in the array.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    typedef enum logic [1:0] {
        PH_INIT = 2'd0,
        PH_IDLE = 2'd1,
        PH_LOAD = 2'd2,
        PH_PROG = 2'd3
    } phase_e;

endpackage

// File: rtl/eepw_strobe.sv
module eepw_strobe #(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 8,
    parameter int MIN_PULSE = 2,
    localparam int WW       = $clog2(MIN_PULSE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              strobe,
    output logic              commit,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);

    typedef struct packed {
        logic              act;
        logic [WW-1:0]     width;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } stb_t;

    stb_t q, d;

    always_comb begin
        d      = q;
        strobe = !ce_n && !we_n && oe_n;
        d.act  = strobe;
        if (strobe) begin
            if (!q.act) begin
                // first active cycle: the later of the two enable falls
                d.addr  = addr;
                d.width = WW'(1);
            end else if (q.width != WW'(MIN_PULSE)) begin
                d.width = q.width + 1'b1;
            end
            // keep overwriting until the first rise ends the strobe
            d.data = din;
        end
        commit   = !strobe && q.act && (q.width == WW'(MIN_PULSE));
        cap_addr = q.addr;
        cap_data = q.data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/eepw_array.sv
module eepw_array #(
    parameter int AW = 10,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eepw_pkg::*;
#(
    parameter int ROW_W      = 4,
    parameter int PAGE_BYTES = 64,
    parameter int DATA_W     = 8,
    parameter int MIN_PULSE  = 2,
    parameter int LOAD_CYC   = 20,
    parameter int PROG_CYC   = 100,
    parameter int INIT_CYC   = 30,
    localparam int COL_W     = $clog2(PAGE_BYTES),
    localparam int ADDR_W    = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en
);

    localparam int LT_W = $clog2(LOAD_CYC + 1);
    localparam int PC_W = $clog2(PROG_CYC + 1);
    localparam int IN_W = $clog2(INIT_CYC + 1);

    typedef struct packed {
        phase_e                             ph;
        logic [IN_W-1:0]                    init_cnt;
        logic [LT_W-1:0]                    tmr;
        logic [PC_W-1:0]                    pcnt;
        logic [ROW_W-1:0]                   row;
        logic [PAGE_BYTES-1:0]              vld;
        logic [PAGE_BYTES-1:0][DATA_W-1:0]  pbuf;
        logic                               last_msb;
        logic                               tog;
        logic                               oen;
        logic [DATA_W-1:0]                  dout;
    } ctl_t;

    ctl_t q, d;

    logic              strobe, commit, rd;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data, mem_rdata, mem_wdata;
    logic [ADDR_W-1:0] mem_waddr;
    logic              mem_we;
    logic [COL_W-1:0]  ccol, pcol;

    eepw_strobe #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .MIN_PULSE(MIN_PULSE)
    ) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .din     (din),
        .strobe  (strobe),
        .commit  (commit),
        .cap_addr(cap_addr),
        .cap_data(cap_data)
    );

    eepw_array #(
        .AW(ADDR_W),
        .DW(DATA_W)
    ) u_array (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(addr),
        .rdata(mem_rdata)
    );

    assign ccol = cap_addr[COL_W-1:0];
    assign pcol = q.pcnt[COL_W-1:0];
    assign rd   = !ce_n && !oe_n && we_n;

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_waddr = {q.row, pcol};
        mem_wdata = q.pbuf[pcol];

        // read path: registered output
        d.oen  = rd;
        d.dout = '0;
        if (rd) begin
            if (q.ph == PH_PROG) begin
                if (!q.oen) d.tog = ~q.tog;
                d.dout[DATA_W-1] = ~q.last_msb;
                d.dout[DATA_W-2] = d.tog;
            end else begin
                d.dout = mem_rdata;
            end
        end

        unique case (q.ph)
            PH_INIT: begin
                if (q.init_cnt == IN_W'(INIT_CYC - 1)) d.ph = PH_IDLE;
                else                                    d.init_cnt = q.init_cnt + 1'b1;
            end
            PH_IDLE, PH_LOAD: begin
                if (commit) begin
                    d.pbuf[ccol] = cap_data;
                    d.vld[ccol]  = 1'b1;
                    d.row        = cap_addr[ADDR_W-1:COL_W];
                    d.last_msb   = cap_data[DATA_W-1];
                    d.tmr        = '0;
                    d.ph         = PH_LOAD;
                end else if (q.ph == PH_LOAD && !strobe) begin
                    if (q.tmr == LT_W'(LOAD_CYC - 1)) begin
                        d.ph   = PH_PROG;
                        d.pcnt = '0;
                        d.tog  = 1'b0;
                    end else begin
                        d.tmr = q.tmr + 1'b1;
                    end
                end
            end
            PH_PROG: begin
                mem_we = (int'(q.pcnt) < PAGE_BYTES) && q.vld[pcol];
                if (q.pcnt == PC_W'(PROG_CYC - 1)) begin
                    d.ph   = PH_IDLE;
                    d.vld  = '0;
                    d.pbuf = '0;
                end else begin
                    d.pcnt = q.pcnt + 1'b1;
                end
            end
            default: d.ph = PH_INIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign dout    = q.dout;
    assign dout_en = q.oen;

    // observation points for the bound checker
    logic                  chk_prog, chk_init, chk_we, chk_msb;
    logic [PAGE_BYTES-1:0] chk_vld;
    assign chk_prog = (q.ph == PH_PROG);
    assign chk_init = (q.ph == PH_INIT);
    assign chk_we   = mem_we;
    assign chk_msb  = q.last_msb;
    assign chk_vld  = q.vld;

endmodule

// File: rtl/eepw_checker.sv
module eepw_checker #(
    parameter int PAGE_BYTES = 64,
    parameter int DATA_W     = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  ce_n,
    input logic                  we_n,
    input logic                  oe_n,
    input logic [DATA_W-1:0]     dout,
    input logic                  dout_en,
    input logic                  in_prog,
    input logic                  in_init,
    input logic                  mem_we,
    input logic                  last_msb,
    input logic [PAGE_BYTES-1:0] vld
);

    logic rd;
    assign rd = !ce_n && !oe_n && we_n;

    a_r1_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_en |-> dout == '0);

    a_r1_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> dout_en);

    a_r1_no_read_float: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !dout_en);

    a_r9_inhibit_empty: assert property (@(posedge clk) disable iff (!rst_n)
        in_init |-> (vld == '0 && !mem_we));

    a_r5_write_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> in_prog);

    a_r8_page_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        in_prog |=> (in_prog ? $stable(vld) : (vld == '0)));

    a_r7_poll_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (in_prog && rd) |=> (dout[DATA_W-1] == ~last_msb && dout[DATA_W-3:0] == '0));

endmodule

bind eeprom_page_writer eepw_checker #(
    .PAGE_BYTES(PAGE_BYTES),
    .DATA_W    (DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .oe_n    (oe_n),
    .dout    (dout),
    .dout_en (dout_en),
    .in_prog (chk_prog),
    .in_init (chk_init),
    .mem_we  (chk_we),
    .last_msb(chk_msb),
    .vld     (chk_vld)
);

// File: tb/eeprom_page_writer_bench.sv
module eeprom_page_writer_bench;

    localparam int MINP = 2;
    localparam int LOAD = 20;
    localparam int PROG = 100;
    localparam int INIT = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [9:0] addr = '0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       dout_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    eeprom_page_writer #(
        .ROW_W(4), .PAGE_BYTES(64), .DATA_W(8), .MIN_PULSE(MINP),
        .LOAD_CYC(LOAD), .PROG_CYC(PROG), .INIT_CYC(INIT)
    ) u_eeprom_page_writer (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_en(dout_en)
    );

    // behavioural reference model
    int       m_ph, m_cnt, m_tmr, m_pc, m_row, m_w;
    bit [7:0] m_mem [1024];
    bit [7:0] m_pg [64];
    bit       m_v [64];
    bit       m_l7, m_tog, m_act, m_oen;
    bit [9:0] m_sa;
    bit [7:0] m_sd, m_out;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_tmr = 0; m_pc = 0; m_row = 0; m_w = 0;
            m_l7 = 0; m_tog = 0; m_act = 0; m_oen = 0; m_sa = 0; m_sd = 0; m_out = 0;
            for (int i = 0; i < 1024; i++) m_mem[i] = 8'hFF;
            for (int i = 0; i < 64; i++) begin m_pg[i] = 0; m_v[i] = 0; end
        end else begin
            bit wr, rd, cm;
            wr = !ce_n && !we_n && oe_n;
            rd = !ce_n && !oe_n && we_n;
            cm = !wr && m_act && (m_w >= MINP);
            if (rd) begin
                if (m_ph == 3) begin
                    if (!m_oen) m_tog = !m_tog;
                    m_out = {~m_l7, m_tog, 6'b0};
                end else m_out = m_mem[int'(addr)];
            end else m_out = 0;
            m_oen = rd;
            if (m_ph == 0) begin
                if (m_cnt == INIT - 1) m_ph = 1; else m_cnt++;
            end else if (m_ph == 1 || m_ph == 2) begin
                if (cm) begin
                    m_pg[m_sa % 64] = m_sd; m_v[m_sa % 64] = 1;
                    m_row = m_sa / 64; m_l7 = m_sd[7]; m_tmr = 0; m_ph = 2;
                end else if (m_ph == 2 && !wr) begin
                    if (m_tmr == LOAD - 1) begin m_ph = 3; m_pc = 0; m_tog = 0; end
                    else m_tmr++;
                end
            end else begin
                if (m_pc < 64 && m_v[m_pc]) m_mem[m_row * 64 + m_pc] = m_pg[m_pc];
                if (m_pc == PROG - 1) begin
                    m_ph = 1;
                    for (int i = 0; i < 64; i++) begin m_pg[i] = 0; m_v[i] = 0; end
                end else m_pc++;
            end
            if (wr) begin
                if (!m_act) begin m_sa = addr; m_w = 1; end else m_w++;
                m_sd = din;
            end
            m_act = wr;
        end
    end

    // per-cycle comparison against the model (R1, R7 on every read)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_chk++;
            if (dout !== m_out || dout_en !== m_oen) begin
                n_fail++;
                $display("FAIL R1/R7 cycle compare: got %0h/%0b expected %0h/%0b",
                         dout, dout_en, m_out, m_oen);
            end
        end
    end

    task automatic check(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input int a, input logic [7:0] d, input int w);
        @(negedge clk);
        addr = 10'(a); din = d; oe_n = 1'b1; we_n = 1'b0; ce_n = 1'b0;
        repeat (w) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read(input int a, output logic [7:0] v, output logic e);
        @(negedge clk);
        addr = 10'(a); we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        v = dout; e = dout_en;
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    function automatic int ad(input int row, input int col);
        return row * 64 + col;
    endfunction

    initial begin
        logic [7:0] v;
        logic       e;
        idle(3);
        check("R1", "reset dout_en", int'(dout_en), 0);
        check("R1", "reset dout", int'(dout), 0);
        rst_n = 1'b1;

        // R9: write inside the inhibit window
        do_write(5, 8'hAA, 3);
        idle(INIT + LOAD + PROG);
        do_read(5, v, e);
        check("R9", "inhibited write", int'(v), 8'hFF);
        check("R1", "read drives bus", int'(e), 1);
        do_read(ad(3, 3), v, e);
        check("R10", "erased after reset", int'(v), 8'hFF);

        // R5/R7: three bytes in row 2
        do_write(ad(2, 0), 8'h3C, 3);
        do_write(ad(2, 1), 8'hC5, 3);
        do_write(ad(2, 63), 8'h81, 3);
        idle(LOAD + 5);
        do_read(ad(2, 0), v, e);
        check("R7", "first poll", int'(v), 8'h40);
        do_read(ad(2, 0), v, e);
        check("R7", "second poll", int'(v), 8'h00);
        idle(PROG);
        do_read(ad(2, 0), v, e);  check("R5", "row2 col0", int'(v), 8'h3C);
        do_read(ad(2, 1), v, e);  check("R5", "row2 col1", int'(v), 8'hC5);
        do_read(ad(2, 63), v, e); check("R5", "row2 col63", int'(v), 8'h81);
        do_read(ad(2, 2), v, e);  check("R5", "row2 col2 untouched", int'(v), 8'hFF);

        // R3: short strobe
        do_write(ad(4, 9), 8'h55, 1);
        do_read(ad(4, 9), v, e);
        check("R3", "no polling after glitch", int'(v), 8'hFF);
        idle(LOAD + PROG);
        do_read(ad(4, 9), v, e);
        check("R3", "glitch not stored", int'(v), 8'hFF);

        // R2: chip-enable controlled write, address and data moving
        @(negedge clk); we_n = 1'b0; oe_n = 1'b1; ce_n = 1'b1; addr = 10'(ad(5, 3)); din = 8'h11;
        @(negedge clk); ce_n = 1'b0;
        @(negedge clk); addr = 10'(ad(5, 8)); din = 8'h22;
        @(negedge clk); din = 8'h7E;
        @(negedge clk); we_n = 1'b1;
        @(negedge clk); ce_n = 1'b1;
        idle(LOAD + PROG + 5);
        do_read(ad(5, 3), v, e); check("R2", "late-fall address, early-rise data", int'(v), 8'h7E);
        do_read(ad(5, 8), v, e); check("R2", "moved address unused", int'(v), 8'hFF);

        // R4: long strobe pauses the load timer
        do_write(ad(6, 0), 8'h10, 2);
        idle(10);
        do_write(ad(6, 1), 8'h20, LOAD + 10);
        do_read(ad(6, 1), v, e);
        check("R4", "still loading after long strobe", int'(v), 8'hFF);
        idle(LOAD + PROG + 5);
        do_read(ad(6, 0), v, e); check("R4", "row6 col0", int'(v), 8'h10);
        do_read(ad(6, 1), v, e); check("R4", "row6 col1", int'(v), 8'h20);

        // R8: write during programming ignored, buffer cleared afterwards
        do_write(ad(7, 0), 8'h99, 3);
        idle(LOAD + 5);
        do_write(ad(7, 1), 8'h66, 3);
        idle(PROG + 5);
        do_read(ad(7, 0), v, e); check("R8", "row7 col0", int'(v), 8'h99);
        do_read(ad(7, 1), v, e); check("R8", "write during program ignored", int'(v), 8'hFF);
        do_write(ad(8, 5), 8'h05, 3);
        idle(LOAD + PROG + 5);
        do_read(ad(8, 5), v, e); check("R8", "row8 col5", int'(v), 8'h05);
        do_read(ad(8, 0), v, e); check("R8", "old buffer byte not reused", int'(v), 8'hFF);

        // R6: row of the last byte wins
        do_write(ad(9, 4), 8'h44, 3);
        do_write(ad(10, 7), 8'h77, 3);
        idle(LOAD + PROG + 5);
        do_read(ad(10, 4), v, e); check("R6", "row10 col4", int'(v), 8'h44);
        do_read(ad(10, 7), v, e); check("R6", "row10 col7", int'(v), 8'h77);
        do_read(ad(9, 4), v, e);  check("R6", "row9 col4 untouched", int'(v), 8'hFF);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule